// File: doc/BRIEF.md
# Center-Aligned PWM Timer with Clock Divider

The block is an up/down timer/counter that produces a symmetric, center-aligned pulse-width-modulated output. A counter climbs from zero to its top value and then falls back to zero. The output level is decided by comparing the count against a compare register. Counting is paced by a clock enable from a divider. The divider is selected by a 3-bit code and offers seven division ratios, from 1 to 1024, plus a stop setting.

The compare value is held in a shadow stage. It reaches the comparator only when the count arrives at its top value. Two compare values have a fixed meaning: zero pins the output to its inactive level, and the top value pins it to its active level. When the counter reaches its top value, the output is forced to the level that an up-counting match would have left. This keeps the waveform mirror-symmetric around zero even when no match took place. Two sticky flags are provided, one for arrival at zero and one for compare matches. Each is cleared by a pulse on its own input.

The counter width is a parameter with a default of 8 bits. The output period is 2·(2^W−1) divided ticks, which is 510 ticks at the default width.

Top module: `pcpwm_timer`

## Requirements
- R1: After a synchronous reset, the count is 0, the counter direction is up, the internal waveform level is low (so pwm_out equals inv), both flags are 0, and the active compare value is 0.
- R2: Select codes 1 to 7 divide the clock by 1, 8, 32, 64, 128, 256 and 1024. Select code 0, or en low, freezes both the divider and the count. A change of the select code restarts the divider. The first tick at the new setting comes N cycles after the first cycle in which the new code is seen.
- R3: On each tick the count moves by one. It climbs from 0 to TOP = 2^W−1, then falls back to 0, so one output period is 2·TOP ticks.
- R4: With a mid-range compare value C, in non-inverted polarity, the level goes low on the tick where the rising count reaches C and goes high on the tick where the falling count reaches C. The high time is therefore 2·C ticks per period.
- R5: An active compare value of 0 keeps the level low at all times. An active compare value of TOP keeps the level high at all times.
- R6: On the tick where the count reaches TOP, and the active compare value is neither 0 nor TOP, the level goes low. This applies even when no compare match happened, for example when the compare value has just left TOP.
- R7: cmp_in is copied into the active compare value only on the tick where the count reaches TOP. A write at any other time has no effect on the output until then.
- R8: ovf_flag sets on the tick where the count reaches 0 and stays set until ovf_clr is pulsed. If a set and a clear happen in the same cycle, the set wins.
- R9: cmp_flag sets on each tick where the new count equals the active compare value and stays set until cmp_clr is pulsed. If a set and a clear happen in the same cycle, the set wins.
- R10: When inv is 1, pwm_out is the complement of the waveform level. The change takes effect at once, without a clock edge.
- R11: In steady state, over one full period, pwm_out is high for 2·C·N cycles out of 2·TOP·N, where N is the division ratio. With inv = 1 the high time is the remainder of the period. This holds for every division setting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Run enable for the divider and the counter |
| clk_sel | input | 3 | Divider select: 0 stop, 1 to 7 for ÷1, ÷8, ÷32, ÷64, ÷128, ÷256, ÷1024 |
| cmp_in | input | W | Compare value written to the shadow stage |
| inv | input | 1 | Output polarity: 1 inverts the waveform |
| ovf_clr | input | 1 | Pulse to clear ovf_flag |
| cmp_clr | input | 1 | Pulse to clear cmp_flag |
| pwm_out | output | 1 | PWM output |
| count | output | W | Current count value |
| ovf_flag | output | 1 | Sticky flag for arrival at zero |
| cmp_flag | output | 1 | Sticky flag for a compare match |

## Verification
The bench builds the timer with W = 4, which makes TOP 15 and the period 30 ticks. This small width puts a full steady-state period within reach for every divider setting, including ÷1024. Duty can therefore be measured exactly for each ratio, rather than only for the fast settings. The small width also means the extreme compare values, the switch from TOP to a mid-range value, and the freeze cases are all reached within a few hundred cycles, and all of them are compared against the behavioural model on every cycle.

// File: rtl/pcpwm_timer.sv
module pcpwm_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [2:0]   clk_sel,
  input  logic [W-1:0] cmp_in,
  input  logic         inv,
  input  logic         ovf_clr,
  input  logic         cmp_clr,
  output logic         pwm_out,
  output logic [W-1:0] count,
  output logic         ovf_flag,
  output logic         cmp_flag
);
  localparam int PW = 10;
  localparam logic [W-1:0] TOP = '1;
  localparam logic [W-1:0] BOT = '0;

  logic [PW-1:0] pre_cnt, pre_lim;
  logic [2:0]    sel_q;
  logic          tick;

  always_comb begin
    case (clk_sel)
      3'd2:    pre_lim = PW'(7);
      3'd3:    pre_lim = PW'(31);
      3'd4:    pre_lim = PW'(63);
      3'd5:    pre_lim = PW'(127);
      3'd6:    pre_lim = PW'(255);
      3'd7:    pre_lim = PW'(1023);
      default: pre_lim = '0;
    endcase
  end

  assign tick = en && (clk_sel != 3'd0) && (clk_sel == sel_q) && (pre_cnt == pre_lim);

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_cnt <= '0;
      sel_q   <= 3'd0;
    end else begin
      sel_q <= clk_sel;
      if (clk_sel != sel_q || tick)
        pre_cnt <= '0;
      else if (en && clk_sel != 3'd0)
        pre_cnt <= pre_cnt + 1'b1;
    end
  end

  logic         up, lvl, lvl_nx;
  logic [W-1:0] cnt, cnt_nx, ocr, ocr_nx;

  assign cnt_nx = up ? cnt + 1'b1 : cnt - 1'b1;
  assign ocr_nx = (cnt_nx == TOP) ? cmp_in : ocr;

  always_comb begin
    if (ocr_nx == BOT)         lvl_nx = 1'b0;
    else if (ocr_nx == TOP)    lvl_nx = 1'b1;
    else if (cnt_nx == TOP)    lvl_nx = 1'b0;
    else if (cnt_nx == ocr_nx) lvl_nx = !up;
    else                       lvl_nx = lvl;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= BOT;
      up       <= 1'b1;
      ocr      <= BOT;
      lvl      <= 1'b0;
      ovf_flag <= 1'b0;
      cmp_flag <= 1'b0;
    end else begin
      if (tick) begin
        cnt <= cnt_nx;
        ocr <= ocr_nx;
        lvl <= lvl_nx;
        if (cnt_nx == TOP)      up <= 1'b0;
        else if (cnt_nx == BOT) up <= 1'b1;
      end
      if (tick && cnt_nx == BOT) ovf_flag <= 1'b1;
      else if (ovf_clr)          ovf_flag <= 1'b0;
      if (tick && cnt_nx == ocr_nx) cmp_flag <= 1'b1;
      else if (cmp_clr)             cmp_flag <= 1'b0;
    end
  end

  assign pwm_out = lvl ^ inv;
  assign count   = cnt;

  a_r3_unit_step: assert property (@(posedge clk) disable iff (rst)
    tick |=> (cnt == $past(cnt) + 1'b1) || (cnt == $past(cnt) - 1'b1));
  a_r2_frozen_hold: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(cnt));
  a_r3_turn_at_top: assert property (@(posedge clk) disable iff (rst)
    (cnt == TOP) |-> !up);
  a_r3_turn_at_bottom: assert property (@(posedge clk) disable iff (rst)
    (cnt == BOT) |-> up);
  a_r5_bottom_low: assert property (@(posedge clk) disable iff (rst)
    (ocr == BOT) |-> !lvl);
  a_r5_top_high: assert property (@(posedge clk) disable iff (rst)
    (ocr == TOP) |-> lvl);
  a_r7_load_at_top: assert property (@(posedge clk) disable iff (rst)
    !$stable(ocr) |-> (cnt == TOP));
  a_r8_ovf_at_bottom: assert property (@(posedge clk) disable iff (rst)
    $rose(ovf_flag) |-> (cnt == BOT));
endmodule

// File: tb/pcpwm_timer_tb.sv
module pcpwm_timer_tb;
  localparam int W = 4;
  localparam int TOPV = (1 << W) - 1;

  logic clk = 1'b0, rst = 1'b1, en = 1'b0, inv = 1'b0, ovf_clr = 1'b0, cmp_clr = 1'b0;
  logic [2:0] clk_sel = 3'd0;
  logic [W-1:0] cmp_in = '0;
  logic pwm_out, ovf_flag, cmp_flag;
  logic [W-1:0] count;

  int checks = 0, fails = 0;
  bit done = 0;

  pcpwm_timer #(.W(W)) u_dut (
    .clk(clk), .rst(rst), .en(en), .clk_sel(clk_sel), .cmp_in(cmp_in), .inv(inv),
    .ovf_clr(ovf_clr), .cmp_clr(cmp_clr), .pwm_out(pwm_out), .count(count),
    .ovf_flag(ovf_flag), .cmp_flag(cmp_flag));

  always #5 clk = ~clk;

  function automatic int ratio(input int s);
    case (s)
      1: return 1;    2: return 8;   3: return 32;  4: return 64;
      5: return 128;  6: return 256; 7: return 1024;
      default: return 0;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  int m_cnt = 0, m_up = 1, m_ocr = 0, m_lvl = 0, m_pre = 0, m_selq = 0, m_ovf = 0, m_cf = 0;

  always @(posedge clk) begin
    int s, nc;
    bit tk;
    s = int'(clk_sel);
    if (rst) begin
      m_cnt = 0; m_up = 1; m_ocr = 0; m_lvl = 0; m_pre = 0; m_selq = 0; m_ovf = 0; m_cf = 0;
    end else begin
      tk = en && s != 0 && s == m_selq && m_pre == ratio(s) - 1;
      if (s != m_selq || tk) m_pre = 0;
      else if (en && s != 0) m_pre = m_pre + 1;
      m_selq = s;
      if (tk) begin
        nc = m_up ? m_cnt + 1 : m_cnt - 1;
        if (nc == TOPV) m_ocr = int'(cmp_in);
        if (m_ocr == 0) m_lvl = 0;
        else if (m_ocr == TOPV) m_lvl = 1;
        else if (nc == TOPV) m_lvl = 0;
        else if (nc == m_ocr) m_lvl = m_up ? 0 : 1;
        if (nc == TOPV) m_up = 0;
        if (nc == 0) m_up = 1;
        m_cnt = nc;
      end
      if (tk && m_cnt == 0 && nc == 0) m_ovf = 1;
      else if (ovf_clr) m_ovf = 0;
      if (tk && m_cnt == m_ocr) m_cf = 1;
      else if (cmp_clr) m_cf = 0;
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      chk(int'(count) == m_cnt, "R3 count", int'(count), m_cnt);
      chk(int'(pwm_out) == (m_lvl ^ int'(inv)), "R4 pwm_out", int'(pwm_out), m_lvl ^ int'(inv));
      chk(int'(ovf_flag) == m_ovf, "R8 ovf_flag", int'(ovf_flag), m_ovf);
      chk(int'(cmp_flag) == m_cf, "R9 cmp_flag", int'(cmp_flag), m_cf);
    end
  end

  task automatic duty(input int s, input int c, input bit iv, input string req);
    int per, hi, ex;
    clk_sel = 3'(s); cmp_in = W'(c); inv = iv;
    per = 2 * TOPV * ratio(s);
    repeat (2 * per) @(negedge clk);
    hi = 0;
    for (int i = 0; i < per; i++) begin
      @(negedge clk);
      if (pwm_out) hi++;
    end
    ex = iv ? per - 2 * c * ratio(s) : 2 * c * ratio(s);
    chk(hi == ex, req, hi, ex);
  endtask

  initial begin
    int held;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(count == '0 && pwm_out == 1'b0 && !ovf_flag && !cmp_flag, "R1 reset state",
        int'(count), 0);
    en = 1'b1;
    duty(1, 0, 0, "R5 bottom pinned low R11");
    duty(1, TOPV, 0, "R5 top pinned high R11");
    cmp_in = W'(5);
    while (count != '0) @(negedge clk);
    while (count != W'(TOPV - 1)) @(negedge clk);
    chk(pwm_out == 1'b1, "R7 shadow value not yet active", int'(pwm_out), 1);
    @(negedge clk);
    chk(count == W'(TOPV) && pwm_out == 1'b0, "R6 forced low at top", int'(pwm_out), 0);
    duty(1, 7, 0, "R4 R11 mid duty");
    duty(1, 7, 1, "R10 inverted duty");
    duty(1, 1, 0, "R11 duty C=1");
    duty(1, TOPV - 1, 1, "R10 R11 inverted C=TOP-1");
    inv = 1'b0;
    chk(ovf_flag && cmp_flag, "R8 R9 flags set after run", int'(ovf_flag), 1);
    clk_sel = 3'd0;
    @(negedge clk);
    held = int'(count);
    repeat (40) @(negedge clk);
    chk(int'(count) == held, "R2 select 0 freezes", int'(count), held);
    ovf_clr = 1'b1; @(negedge clk); ovf_clr = 1'b0;
    chk(!ovf_flag && cmp_flag, "R8 ovf cleared", int'(ovf_flag), 0);
    cmp_clr = 1'b1; @(negedge clk); cmp_clr = 1'b0;
    chk(!cmp_flag, "R9 cmp cleared", int'(cmp_flag), 0);
    clk_sel = 3'd2; en = 1'b0;
    @(negedge clk);
    held = int'(count);
    repeat (60) @(negedge clk);
    chk(int'(count) == held, "R2 enable low freezes", int'(count), held);
    en = 1'b1;
    duty(2, 3, 0, "R2 R11 divide 8");
    duty(3, 9, 0, "R11 divide 32");
    duty(4, 12, 1, "R11 divide 64 inverted");
    duty(5, 6, 0, "R11 divide 128");
    duty(6, 10, 0, "R11 divide 256");
    duty(7, 4, 0, "R11 divide 1024");
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog R3 actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule